// File: doc/BRIEF.md
# PCIe Inbound Window Address Translator

This block sits on the inbound side of a PCIe endpoint. It takes the 64-bit address of each incoming request and compares it against a small bank of programmable windows. Each window holds a base address, a compact size code and a translation base. On a match, it produces a narrower AXI address. The low offset bits inside the window are kept, and the upper bits come from the translation base. The AXI-side address windows play no part in this decode.

Even-numbered windows can be declared 64-bit. A 64-bit window takes over the odd slot above it, and that odd slot then never matches. Odd slots, and even slots left as 32-bit, only decode addresses below 4 GB. A window is flagged as badly configured when any of the following holds:
- its translation base has bits set above the AXI width;
- its translation base has bits set inside the window's offset range;
- its size code is out of range.

Requests travel over a valid/ready pair and are answered one cycle later through a registered response with its own valid/ready pair. A response gives one of three outcomes: a hit with the winning window index, a miss, or a bad-configuration refusal. Configuration writes are only accepted while the datapath is idle.

Top module: `pcie_win_xlate`

## Requirements
- R1: A size code c gives a window of 2^(c+7) bytes. On a hit, bits c+6..0 of the response address come from the request and all higher bits, up to the AXI width, come from the translation base.
- R2: A window matches when the request address bits from c+7 upward equal the same bits of the window base. Base bits below c+7 are ignored.
- R3: When an even slot is enabled with its 64-bit flag set, the odd slot above it never matches. A slot that is not 64-bit (every odd slot, and any even slot with the flag clear) treats base bits 63..32 as zero.
- R4: When several windows match, the lowest-numbered one wins.
- R5: An enabled, active window whose translation base has any of bits 63..AXI_AW set is flagged in `win_bad`. A request whose winning window is flagged gets a response with `rsp_bad`=1, `rsp_hit`=0 and a zero address.
- R6: A translation base with any bit set below bit c+7 flags the window as in R5.
- R7: A size code above 56 flags the window as in R5.
- R8: A request that matches no active window gets a response with `rsp_hit`=0, `rsp_bad`=0, `rsp_win`=0 and a zero address.
- R9: A request accepted at a clock edge (`req_valid` and `req_ready` high) shows `rsp_valid`=1 after that edge. `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_ready` is low, the response and all its fields hold.
- R10: `cfg_ready` is high only when `rsp_valid` and `req_valid` are both low. A write presented while `cfg_ready` is low is dropped.
- R11: After reset every window is disabled, `rsp_valid`=0, `win_bad`=0, and any request misses.
- R12: Configuration writes select a field with `cfg_sel`:
  - 0 writes the base;
  - 1 writes the translation base;
  - 2 writes control, with bits 5..0 the size code, bit 6 enable and bit 7 the 64-bit flag;
  - 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Window slot to write |
| cfg_sel | input | 2 | Field select (0 base, 1 translation, 2 control) |
| cfg_wdata | input | 64 | Write data |
| cfg_ready | output | 1 | Writes accepted this cycle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | 64 | PCIe request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream ready |
| rsp_hit | output | 1 | Request hit a good window |
| rsp_bad | output | 1 | Winning window is badly configured |
| rsp_win | output | SLOT_W | Winning window index (0 on miss) |
| rsp_axi_addr | output | AXI_AW | Translated AXI address (0 unless hit) |
| win_bad | output | NUM_WIN | Per-window bad-configuration flags |

## Verification
The bench builds the block with its defaults: six window slots and a 48-bit AXI address. Six slots yield three even/odd pairs. One pair holds a 64-bit window that shadows an enabled odd slot. Two 32-bit slots in another pair overlap, which brings the lowest-index priority rule and the forced-zero upper base bits within reach. With a 48-bit AXI width, bits 63..48 of a translation base are writable but illegal, so the over-width check can actually be triggered. Offset ranges from 4 KB to 32 MB exercise both edges of the offset/upper split.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

    localparam int REQ_AW    = 64;
    localparam int CODE_W    = 6;
    localparam int MIN_SHIFT = 7;
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(REQ_AW - 1 - MIN_SHIFT);

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_XLAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [REQ_AW-1:0] base;
        logic [REQ_AW-1:0] xlat;
        logic [CODE_W-1:0] code;
        logic              en;
        logic              is64;
    } win_cfg_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return code <= MAX_CODE;
    endfunction

    function automatic logic [REQ_AW-1:0] off_mask(input logic [CODE_W-1:0] code);
        logic [REQ_AW-1:0] m;
        if (!code_ok(code))
            m = '1;
        else
            m = (REQ_AW'(1) << (int'(code) + MIN_SHIFT)) - REQ_AW'(1);
        return m;
    endfunction

endpackage

// File: rtl/pwx_cfg_bank.sv
module pwx_cfg_bank
    import pwx_pkg::*;
#(
    parameter int NUM_WIN = 6,
    localparam int SLOT_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic                     cfg_open,
    input  logic [SLOT_W-1:0]        cfg_slot,
    input  logic [1:0]               cfg_sel,
    input  logic [REQ_AW-1:0]        cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]   cfg_q
);

    logic wr_ok;
    assign wr_ok = cfg_we && cfg_open;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wr_ok && cfg_slot == SLOT_W'(i)) begin
                case (cfg_sel_e'(cfg_sel))
                    SEL_BASE: cfg_q[i].base <= cfg_wdata;
                    SEL_XLAT: cfg_q[i].xlat <= cfg_wdata;
                    SEL_CTRL: begin
                        cfg_q[i].code <= cfg_wdata[CODE_W-1:0];
                        cfg_q[i].en   <= cfg_wdata[6];
                        cfg_q[i].is64 <= cfg_wdata[7];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: a write offered while the datapath is busy leaves the bank untouched
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_open) |=> $stable(cfg_q));

endmodule

// File: rtl/pwx_win_check.sv
module pwx_win_check
    import pwx_pkg::*;
#(
    parameter int AXI_AW = 48,
    parameter bit IS_ODD = 1'b0
) (
    input  win_cfg_t            cfg,
    input  logic                shadowed,
    input  logic [REQ_AW-1:0]   req_addr,
    output logic                active,
    output logic                bad,
    output logic                match,
    output logic [AXI_AW-1:0]   axi_addr
);

    localparam logic [REQ_AW-1:0] AXI_KEEP = (REQ_AW'(1) << AXI_AW) - REQ_AW'(1);

    logic [REQ_AW-1:0] mask;
    logic [REQ_AW-1:0] eff_base;
    logic [REQ_AW-1:0] full;
    logic              wide;

    always_comb begin
        wide     = cfg.is64 && !IS_ODD;
        mask     = off_mask(cfg.code);
        eff_base = wide ? cfg.base : {32'h0, cfg.base[31:0]};
        active   = cfg.en && !shadowed;
        match    = active && ((req_addr & ~mask) == (eff_base & ~mask));
        bad      = active && (!code_ok(cfg.code)
                              || (|(cfg.xlat & ~AXI_KEEP))
                              || (|(cfg.xlat & mask)));
        full     = (cfg.xlat & ~mask) | (req_addr & mask);
        axi_addr = full[AXI_AW-1:0];
    end

endmodule

// File: rtl/pwx_pick.sv
module pwx_pick #(
    parameter int NUM_WIN = 6,
    parameter int AXI_AW  = 48,
    localparam int SLOT_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0]             match,
    input  logic [NUM_WIN-1:0]             bad,
    input  logic [NUM_WIN-1:0][AXI_AW-1:0] addr,
    output logic                           any,
    output logic                           sel_bad,
    output logic [SLOT_W-1:0]              idx,
    output logic [AXI_AW-1:0]              sel_addr
);

    always_comb begin
        any      = 1'b0;
        sel_bad  = 1'b0;
        idx      = '0;
        sel_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                any      = 1'b1;
                sel_bad  = bad[i];
                idx      = SLOT_W'(i);
                sel_addr = addr[i];
            end
        end
    end

endmodule

// File: rtl/pcie_win_xlate.sv
module pcie_win_xlate
    import pwx_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int AXI_AW  = 48,
    localparam int SLOT_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SLOT_W-1:0]  cfg_slot,
    input  logic [1:0]         cfg_sel,
    input  logic [63:0]        cfg_wdata,
    output logic               cfg_ready,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [63:0]        req_addr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_hit,
    output logic               rsp_bad,
    output logic [SLOT_W-1:0]  rsp_win,
    output logic [AXI_AW-1:0]  rsp_axi_addr,
    output logic [NUM_WIN-1:0] win_bad
);

    win_cfg_t [NUM_WIN-1:0]             cfg_q;
    logic [NUM_WIN-1:0]                 w_active;
    logic [NUM_WIN-1:0]                 w_bad;
    logic [NUM_WIN-1:0]                 w_match;
    logic [NUM_WIN-1:0][AXI_AW-1:0]     w_addr;
    logic                               p_any;
    logic                               p_bad;
    logic [SLOT_W-1:0]                  p_idx;
    logic [AXI_AW-1:0]                  p_addr;
    logic                               fire;

    assign cfg_ready = !rsp_valid && !req_valid;
    assign req_ready = !rsp_valid || rsp_ready;
    assign fire      = req_valid && req_ready;
    assign win_bad   = w_bad;

    pwx_cfg_bank #(.NUM_WIN(NUM_WIN)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_open (cfg_ready),
        .cfg_slot (cfg_slot),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .cfg_q    (cfg_q)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic shadow;
        if (i % 2 == 1) begin : g_odd
            assign shadow = cfg_q[i-1].en && cfg_q[i-1].is64;
        end else begin : g_even
            assign shadow = 1'b0;
        end

        pwx_win_check #(.AXI_AW(AXI_AW), .IS_ODD(i % 2 == 1)) u_chk (
            .cfg      (cfg_q[i]),
            .shadowed (shadow),
            .req_addr (req_addr),
            .active   (w_active[i]),
            .bad      (w_bad[i]),
            .match    (w_match[i]),
            .axi_addr (w_addr[i])
        );

        // R3: a shadowed odd slot is never active
        p_shadow_r3: assert property (@(posedge clk) disable iff (rst)
            shadow |-> !w_active[i]);
    end

    pwx_pick #(.NUM_WIN(NUM_WIN), .AXI_AW(AXI_AW)) u_pick (
        .match    (w_match),
        .bad      (w_bad),
        .addr     (w_addr),
        .any      (p_any),
        .sel_bad  (p_bad),
        .idx      (p_idx),
        .sel_addr (p_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_bad      <= 1'b0;
            rsp_win      <= '0;
            rsp_axi_addr <= '0;
        end else if (fire) begin
            rsp_valid    <= 1'b1;
            rsp_hit      <= p_any && !p_bad;
            rsp_bad      <= p_any && p_bad;
            rsp_win      <= (p_any && !p_bad) ? p_idx : '0;
            rsp_axi_addr <= (p_any && !p_bad) ? p_addr : '0;
        end else if (rsp_ready) begin
            rsp_valid    <= 1'b0;
        end
    end

    // R9: accepted request yields a response after the edge
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    // R9: backpressure holds the response steady
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_axi_addr)
                                      && $stable(rsp_win) && $stable(rsp_hit)
                                      && $stable(rsp_bad)));

    // R8: no address leaves unless the request hit
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_axi_addr == '0 && rsp_win == '0));

    // R5: hit and bad-configuration refusal are exclusive
    p_hit_bad_excl_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_hit && rsp_bad));

endmodule

// File: tb/pcie_win_xlate_test.sv
module pcie_win_xlate_test;

    localparam int NW = 6;
    localparam int AW = 48;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_slot;
    logic [1:0]  cfg_sel;
    logic [63:0] cfg_wdata;
    logic        cfg_ready;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic        rsp_valid;
    logic        rsp_ready;
    logic        rsp_hit;
    logic        rsp_bad;
    logic [2:0]  rsp_win;
    logic [47:0] rsp_axi_addr;
    logic [5:0]  win_bad;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pcie_win_xlate #(.NUM_WIN(NW), .AXI_AW(AW)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_bad(rsp_bad), .rsp_win(rsp_win), .rsp_axi_addr(rsp_axi_addr),
        .win_bad(win_bad)
    );

    typedef struct packed {
        logic [63:0] a;
        logic        hit;
        logic [2:0]  win;
        logic [47:0] axi;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{64'h20000000_ABCDFFF4, 1'b1, 3'd0, 48'h0000_12347FF4},
        '{64'hA0000000_1235FEDC, 1'b1, 3'd2, 48'h0000_FE35FEDC},
        '{64'h20000000_ABCD8000, 1'b1, 3'd0, 48'h0000_12340000},
        '{64'h20000000_ABCE0000, 1'b0, 3'd0, 48'h0},
        '{64'h20000000_ABCD7FFF, 1'b0, 3'd0, 48'h0},
        '{64'h00000000_ABCD8010, 1'b0, 3'd0, 48'h0},
        '{64'h00000000_40000ABC, 1'b1, 3'd4, 48'h1234_56789ABC},
        '{64'hFFFFFFFF_40000ABC, 1'b0, 3'd0, 48'h0},
        '{64'h00000000_40100000, 1'b1, 3'd5, 48'h0000_00300000},
        '{64'h00000000_40000FFF, 1'b1, 3'd4, 48'h1234_56789FFF},
        '{64'hA0000000_11FFFFFF, 1'b0, 3'd0, 48'h0},
        '{64'hA0000000_13FFFFFF, 1'b1, 3'd2, 48'h0000_FFFFFFFF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic cfg_write(input logic [2:0] slot, input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = slot; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [63:0] ctrl(input logic [5:0] code, input logic en, input logic w64);
        return {56'h0, w64, en, code};
    endfunction

    task automatic do_req(input logic [63:0] a);
        @(negedge clk);
        req_addr = a; req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic bad,
                              input logic [2:0] win, input logic [47:0] axi);
        check({req, " valid"}, 64'(rsp_valid), 64'd1);
        check({req, " hit"},   64'(rsp_hit),   64'(hit));
        check({req, " bad"},   64'(rsp_bad),   64'(bad));
        check({req, " win"},   64'(rsp_win),   64'(win));
        check({req, " addr"},  64'(rsp_axi_addr), 64'(axi));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_slot = '0; cfg_sel = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 win_bad",   64'(win_bad),   64'd0);
        check("R11 cfg_ready", 64'(cfg_ready), 64'd1);
        check("R11 req_ready", 64'(req_ready), 64'd1);
        do_req(64'h0);
        expect_rsp("R11 empty bank miss", 1'b0, 1'b0, 3'd0, 48'h0);

        // R12: program windows through the three fields
        cfg_write(3'd0, 2'd0, 64'h20000000_ABCD8000);
        cfg_write(3'd0, 2'd1, 64'h00000000_12340000);
        cfg_write(3'd0, 2'd2, ctrl(6'h08, 1'b1, 1'b1));
        cfg_write(3'd1, 2'd0, 64'h00000000_ABCD8000);
        cfg_write(3'd1, 2'd1, 64'h00000000_07770000);
        cfg_write(3'd1, 2'd2, ctrl(6'h08, 1'b1, 1'b0));
        cfg_write(3'd2, 2'd0, 64'hA0000000_12000000);
        cfg_write(3'd2, 2'd1, 64'h00000000_FE000000);
        cfg_write(3'd2, 2'd2, ctrl(6'h12, 1'b1, 1'b1));
        cfg_write(3'd4, 2'd0, 64'hFFFFFFFF_40000000);
        cfg_write(3'd4, 2'd1, 64'h00001234_56789000);
        cfg_write(3'd4, 2'd2, ctrl(6'h05, 1'b1, 1'b0));
        cfg_write(3'd5, 2'd0, 64'h00000000_40000000);
        cfg_write(3'd5, 2'd1, 64'h00000000_00200000);
        cfg_write(3'd5, 2'd2, ctrl(6'h0E, 1'b1, 1'b0));
        cfg_write(3'd5, 2'd3, 64'hFFFFFFFF_FFFFFFFF);
        @(negedge clk);
        check("R12 win_bad after programming", 64'(win_bad), 64'd0);

        // R1 R2 R3 R4 R8: vector table
        for (int k = 0; k < NV; k++) begin
            do_req(VT[k].a);
            expect_rsp($sformatf("R1/R2/R3/R4/R8 vec %0d", k), VT[k].hit, 1'b0,
                       VT[k].win, VT[k].axi);
        end

        // R9 and R10: backpressure with a blocked config write
        @(negedge clk);
        req_addr = 64'h20000000_ABCDFFF4; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 latency valid", 64'(rsp_valid), 64'd1);
        check("R9 req_ready low", 64'(req_ready), 64'd0);
        check("R10 cfg_ready low", 64'(cfg_ready), 64'd0);
        cfg_we = 1'b1; cfg_slot = 3'd4; cfg_sel = 2'd2; cfg_wdata = 64'h0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 hold valid", 64'(rsp_valid), 64'd1);
        check("R9 hold addr", 64'(rsp_axi_addr), 64'h0000_12347FF4);
        @(negedge clk);
        check("R9 hold addr 2", 64'(rsp_axi_addr), 64'h0000_12347FF4);
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R9 drained", 64'(rsp_valid), 64'd0);
        do_req(64'h00000000_40000ABC);
        expect_rsp("R10 dropped write", 1'b1, 1'b0, 3'd4, 48'h1234_56789ABC);

        // R5: translation bits above AXI width
        cfg_write(3'd5, 2'd1, 64'h00010000_00200000);
        @(negedge clk);
        check("R5 win_bad", 64'(win_bad), 64'h20);
        do_req(64'h00000000_40100000);
        expect_rsp("R5 refused", 1'b0, 1'b1, 3'd0, 48'h0);

        // R6: translation bits inside offset range
        cfg_write(3'd5, 2'd1, 64'h00000000_00200400);
        @(negedge clk);
        check("R6 win_bad", 64'(win_bad), 64'h20);
        do_req(64'h00000000_40100000);
        expect_rsp("R6 refused", 1'b0, 1'b1, 3'd0, 48'h0);
        cfg_write(3'd5, 2'd1, 64'h00000000_00200000);

        // R7: size code out of range
        cfg_write(3'd5, 2'd2, ctrl(6'd57, 1'b1, 1'b0));
        @(negedge clk);
        check("R7 win_bad", 64'(win_bad), 64'h20);
        cfg_write(3'd5, 2'd2, ctrl(6'h0E, 1'b1, 1'b0));
        @(negedge clk);
        check("R7 restored", 64'(win_bad), 64'h0);

        // R3: disabling the 64-bit window exposes the odd slot
        cfg_write(3'd0, 2'd2, ctrl(6'h08, 1'b0, 1'b1));
        do_req(64'h00000000_ABCD8010);
        expect_rsp("R3 odd slot unshadowed", 1'b1, 1'b0, 3'd1, 48'h0000_07770010);

        finish_run();
    end

endmodule